// File: doc/BRIEF.md
# ADC Sample Format Converter

This block sits behind the capture path of a multi-channel ADC interface. Every channel owns a small control register and a formatting lane. A raw sample word comes in with a valid strobe. The lane turns it into a uniform output word of `OUT_W` bits, and the result appears one clock later with its own valid strobe. A single packet-format code is shared by all channels and gives the native width of the incoming samples.

When formatting is enabled, the lane keeps only the native-width bits of the sample. If the channel's data is offset binary, the lane turns it into two's complement by flipping the top native bit. It then fills the bits above the native width in one of two ways: with copies of the new top bit when sign extension is on, or with zeros when it is off. When formatting is disabled, the raw word goes through untouched.

A per-channel enable bit decides whether samples are accepted at all. The parameter `WIDE_VARIANT` picks between the 20-bit build and the 16-bit build of the converter. The two builds map the packet-format codes to different widths.

Top module: `adc_sample_fmt`

## Requirements
- R1: After reset every channel's control holds channel enable = 1, format enable = 1, sign extend = 1 and offset binary = 0.
- R2: Packet-format code `pkt_fmt` gives the native width W. On the 20-bit build (WIDE_VARIANT=1), code 0 means 20, code 1 means 24, code 2 means 32 and code 3 means 20. On the 16-bit build (WIDE_VARIANT=0), code 0 means 16, code 1 means 24, code 2 means 24 and code 3 means 16.
- R3: With format enable (control bit 4) clear, the output word equals the raw input word on all `OUT_W` bits.
- R4: With format enable set and offset binary (control bit 5) set, output bit W-1 is the inverse of input bit W-1, and bits below W-1 equal the input bits.
- R5: With format enable and sign extend (control bit 6) both set, every output bit at W and above equals output bit W-1.
- R6: With format enable set and sign extend clear, every output bit at W and above is zero. Input bits at W and above have no effect on the output.
- R7: With channel enable (control bit 0) clear, a sample on that channel gives no output valid, and that channel's output word keeps its previous value.
- R8: An accepted sample shows up on `out_data` with `out_valid` high exactly one clock after its `in_valid` cycle. In every other cycle `out_valid` is low and `out_data` holds. Reset clears both.
- R9: A pulse on `cfg_we[c]` loads `cfg_wdata` bits 0, 4, 5 and 6 into channel c's control at that clock edge. A sample presented in the same cycle is still formatted with the old control. Other channels are not affected, and `cfg_wdata` bits 1, 2, 3 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | NUM_CH | Per-channel control write strobe |
| cfg_wdata | input | 8 | Control write data (bit 0 enable, 4 format, 5 offset binary, 6 sign extend) |
| pkt_fmt | input | 2 | Packet-format code giving the native sample width |
| in_valid | input | NUM_CH | Per-channel raw sample strobe |
| in_data | input | NUM_CH*OUT_W | Raw samples, channel c in bits [c*OUT_W +: OUT_W] |
| out_valid | output | NUM_CH | Per-channel formatted sample strobe |
| out_data | output | NUM_CH*OUT_W | Formatted samples, same packing as in_data |

## Verification
The bench sweeps all eight combinations of format enable, offset binary and sign extend, across all four packet-format codes. It does this on two channels and on both builds at once. The sample patterns put the top native bit set and clear, and put garbage above the native width.

- A lane that picked the wrong width for a code, or treated code 3 as invalid, would flip or extend the wrong bit.
- A lane that let upper raw bits leak through would show nonzero bits above W with sign extension off.

Two timing cases are also targeted. A control write in the same cycle as a sample must not reach that sample; an early-applied write would format it with the new settings. A disabled channel must keep its last output word; a design that cleared it or raised valid would differ at the port.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  localparam int CTL_W        = 8;
  localparam int CH_EN_BIT    = 0;
  localparam int FMT_EN_BIT   = 4;
  localparam int OFS_BIN_BIT  = 5;
  localparam int SEXT_BIT     = 6;

  typedef struct packed {
    logic sext;
    logic ofs_bin;
    logic fmt_en;
    logic ch_en;
  } lane_ctl_t;

  localparam lane_ctl_t CTL_RESET = '{sext: 1'b1, ofs_bin: 1'b0, fmt_en: 1'b1, ch_en: 1'b1};

  // native width selected by the packet-format code
  function automatic logic [6:0] native_width(input logic [1:0] code, input bit wide);
    case (code)
      2'd1:    native_width = 7'd24;
      2'd2:    native_width = wide ? 7'd32 : 7'd24;
      default: native_width = wide ? 7'd20 : 7'd16;
    endcase
  endfunction

endpackage

// File: rtl/adc_fmt_ctl_reg.sv
module adc_fmt_ctl_reg
  import adc_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output lane_ctl_t        ctl
);

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{wdata[7], wdata[3:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= CTL_RESET;
    end else if (we) begin
      ctl <= '{sext:    wdata[SEXT_BIT],
               ofs_bin: wdata[OFS_BIN_BIT],
               fmt_en:  wdata[FMT_EN_BIT],
               ch_en:   wdata[CH_EN_BIT]};
    end
  end

endmodule

// File: rtl/adc_fmt_lane.sv
module adc_fmt_lane
  import adc_fmt_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_ctl_t        ctl,
  input  logic [6:0]       width,
  input  logic             in_valid,
  input  logic [OUT_W-1:0] in_data,
  output logic             accept,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  // bit-by-bit reshaping of one raw word
  function automatic logic [OUT_W-1:0] reshape(input logic [OUT_W-1:0] raw,
                                               input logic [6:0] w,
                                               input lane_ctl_t c);
    logic [OUT_W-1:0] r;
    logic             top;
    top = raw[w - 7'd1] ^ c.ofs_bin;
    for (int i = 0; i < OUT_W; i++) begin
      if (i == int'(w) - 1)   r[i] = top;
      else if (i < int'(w))   r[i] = raw[i];
      else                    r[i] = c.sext & top;
    end
    return c.fmt_en ? r : raw;
  endfunction

  assign accept = in_valid & ctl.ch_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) out_data <= reshape(in_data, width, ctl);
    end
  end

endmodule

// File: rtl/adc_sample_fmt.sv
module adc_sample_fmt
  import adc_fmt_pkg::*;
#(
  parameter int NUM_CH       = 2,
  parameter int OUT_W        = 32,
  parameter bit WIDE_VARIANT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       cfg_we,
  input  logic [CTL_W-1:0]        cfg_wdata,
  input  logic [1:0]              pkt_fmt,
  input  logic [NUM_CH-1:0]       in_valid,
  input  logic [NUM_CH*OUT_W-1:0] in_data,
  output logic [NUM_CH-1:0]       out_valid,
  output logic [NUM_CH*OUT_W-1:0] out_data
);

  // named internal events for the checker
  logic [6:0]        cur_w;
  logic [NUM_CH-1:0] ch_en_w;
  logic [NUM_CH-1:0] fmt_en_w;
  logic [NUM_CH-1:0] sext_w;
  logic [NUM_CH-1:0] accept_w;

  assign cur_w = native_width(pkt_fmt, WIDE_VARIANT);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lane_ctl_t ctl;

    adc_fmt_ctl_reg u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we[c]),
      .wdata (cfg_wdata),
      .ctl   (ctl)
    );

    adc_fmt_lane #(.OUT_W(OUT_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .width     (cur_w),
      .in_valid  (in_valid[c]),
      .in_data   (in_data[c*OUT_W +: OUT_W]),
      .accept    (accept_w[c]),
      .out_valid (out_valid[c]),
      .out_data  (out_data[c*OUT_W +: OUT_W])
    );

    assign ch_en_w[c]  = ctl.ch_en;
    assign fmt_en_w[c] = ctl.fmt_en;
    assign sext_w[c]   = ctl.sext;
  end

endmodule

// File: rtl/adc_fmt_chk.sv
module adc_fmt_chk #(
  parameter int NUM_CH = 2,
  parameter int OUT_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       in_valid,
  input logic [NUM_CH*OUT_W-1:0] in_data,
  input logic [NUM_CH-1:0]       out_valid,
  input logic [NUM_CH*OUT_W-1:0] out_data,
  input logic [NUM_CH-1:0]       ch_en_w,
  input logic [NUM_CH-1:0]       fmt_en_w,
  input logic [NUM_CH-1:0]       sext_w,
  input logic [6:0]              cur_w
);

  localparam logic [OUT_W-1:0] ONES = {OUT_W{1'b1}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R8
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[c] && ch_en_w[c]) |=> out_valid[c]);
    // R7
    no_valid_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid[c] && ch_en_w[c]) |=> !out_valid[c]);
    // R8
    data_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid[c] && ch_en_w[c]) |=> $stable(out_data[c*OUT_W +: OUT_W]));
    // R3
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[c] && ch_en_w[c] && !fmt_en_w[c]) |=>
        out_data[c*OUT_W +: OUT_W] == $past(in_data[c*OUT_W +: OUT_W]));
    // R6
    zero_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[c] && ch_en_w[c] && fmt_en_w[c] && !sext_w[c]) |=>
        (out_data[c*OUT_W +: OUT_W] >> $past(cur_w)) == '0);
    // R5
    sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[c] && ch_en_w[c] && fmt_en_w[c] && sext_w[c]) |=>
        ((out_data[c*OUT_W +: OUT_W] >> ($past(cur_w) - 7'd1)) == '0) ||
        ((out_data[c*OUT_W +: OUT_W] >> ($past(cur_w) - 7'd1)) == (ONES >> ($past(cur_w) - 7'd1))));
  end

endmodule

bind adc_sample_fmt adc_fmt_chk #(.NUM_CH(NUM_CH), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .ch_en_w   (ch_en_w),
  .fmt_en_w  (fmt_en_w),
  .sext_w    (sext_w),
  .cur_w     (cur_w)
);

// File: tb/sim_adc_sample_fmt.sv
`timescale 1ns/1ps
module sim_adc_sample_fmt;
  localparam int NCH = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  cfg_we = '0;
  logic [7:0]      cfg_wdata = '0;
  logic [1:0]      pkt_fmt = '0;
  logic [NCH-1:0]  in_valid = '0;
  logic [NCH*32-1:0] in_data = '0;
  logic [NCH-1:0]  ov0, ov1;
  logic [NCH*32-1:0] od0, od1;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [3:0] shadow [NCH];   // {sext, ofs, fmt, en} as written by the bench

  always #2.5 clk = ~clk;

  adc_sample_fmt #(.NUM_CH(NCH), .OUT_W(32), .WIDE_VARIANT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pkt_fmt(pkt_fmt),
    .in_valid(in_valid), .in_data(in_data), .out_valid(ov0), .out_data(od0));

  adc_sample_fmt #(.NUM_CH(NCH), .OUT_W(32), .WIDE_VARIANT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pkt_fmt(pkt_fmt),
    .in_valid(in_valid), .in_data(in_data), .out_valid(ov1), .out_data(od1));

  // arithmetic model from the requirements
  function automatic logic [31:0] model(logic [31:0] raw, logic [1:0] code, bit wide, logic [3:0] c);
    int w;
    logic [63:0] mask, v;
    w = (code == 2'd1) ? 24 : (code == 2'd2) ? (wide ? 32 : 24) : (wide ? 20 : 16);
    if (!c[1]) return raw;
    mask = (64'd1 << w) - 64'd1;
    v = {32'd0, raw} & mask;
    if (c[2]) v = v ^ (64'd1 << (w - 1));
    if (c[3] && v[w-1]) v = v | ~mask;
    return v[31:0];
  endfunction

  function automatic logic [31:0] pattern(int p);
    case (p)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0008_0000;
      3: return 32'h0007_FFFF;
      4: return 32'h0080_0000;
      5: return 32'h8000_0000;
      6: return 32'hF000_8000;
      default: return 32'h5A5A_A5A5;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic write_ctl(int ch, logic [7:0] d);
    @(negedge clk);
    cfg_we = '0; cfg_we[ch] = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = '0;
    shadow[ch] = {d[6], d[5], d[4], d[0]};
  endtask

  task automatic send(int ch, logic [31:0] raw, logic [1:0] code, string tag);
    logic [31:0] e0, e1;
    e0 = model(raw, code, 1'b1, shadow[ch]);
    e1 = model(raw, code, 1'b0, shadow[ch]);
    @(negedge clk);
    in_valid = '0; in_valid[ch] = 1'b1; in_data[ch*32 +: 32] = raw; pkt_fmt = code;
    @(negedge clk);
    in_valid = '0;
    chk(ov0[ch] == 1'b1, {tag, " R8 valid"}, 32'(ov0[ch]), 32'd1);
    chk(ov0[1-ch] == 1'b0, {tag, " R8 other valid"}, 32'(ov0[1-ch]), 32'd0);
    chk(od0[ch*32 +: 32] == e0, {tag, " wide"}, od0[ch*32 +: 32], e0);
    chk(od1[ch*32 +: 32] == e1, {tag, " narrow"}, od1[ch*32 +: 32], e1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] held, e;
    for (int c = 0; c < NCH; c++) shadow[c] = 4'b1011;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(ov0 == '0 && ov1 == '0, "R8 reset valid", 32'(ov0), 32'd0);
    chk(od0 == '0, "R8 reset data", od0[31:0], 32'd0);
    rst_n = 1'b1;

    // R1: defaults sign-extend from the native width
    send(0, 32'hABC8_1234, 2'd0, "R1 default ch0");
    send(1, 32'h1234_7FFF, 2'd3, "R1 default ch1");

    // R2..R6 sweep
    for (int ch = 0; ch < NCH; ch++) begin
      for (int cb = 0; cb < 8; cb++) begin
        logic [7:0] d;
        string tag;
        d = {1'b0, cb[2], cb[1], cb[0], 3'b000, 1'b1};
        write_ctl(ch, d);
        tag = !cb[0] ? "R3 pass" : cb[1] ? "R4 ofs" : cb[2] ? "R5 sext" : "R6 zero";
        for (int code = 0; code < 4; code++)
          for (int p = 0; p < 8; p++)
            send(ch, pattern(p), 2'(code), $sformatf("R2 code%0d %s ch%0d", code, tag, ch));
      end
    end

    // R7: disabled channel
    write_ctl(1, 8'h71);
    send(1, 32'h0001_2345, 2'd0, "R7 before");
    held = od0[63:32];
    write_ctl(1, 8'h70);
    @(negedge clk); in_valid[1] = 1'b1; in_data[63:32] = 32'h0009_9999;
    @(negedge clk); in_valid = '0;
    chk(ov0[1] == 1'b0, "R7 no valid", 32'(ov0[1]), 32'd0);
    chk(od0[63:32] == held, "R7 data held", od0[63:32], held);
    write_ctl(1, 8'h51);

    // R8: valid drops and data holds after one cycle
    send(0, 32'h000F_0F0F, 2'd1, "R8 single");
    held = od0[31:0];
    @(negedge clk);
    chk(ov0[0] == 1'b0, "R8 valid drop", 32'(ov0[0]), 32'd0);
    chk(od0[31:0] == held, "R8 hold", od0[31:0], held);

    // R9: same-cycle write uses old control; then new control applies
    write_ctl(0, 8'h71);
    e = model(32'h0008_0001, 2'd0, 1'b1, 4'b1111);
    @(negedge clk);
    cfg_we[0] = 1'b1; cfg_wdata = 8'h01;
    in_valid[0] = 1'b1; in_data[31:0] = 32'h0008_0001; pkt_fmt = 2'd0;
    @(negedge clk);
    cfg_we = '0; in_valid = '0;
    shadow[0] = 4'b0001;
    chk(od0[31:0] == e, "R9 same-cycle old ctl", od0[31:0], e);
    send(0, 32'hDEAD_BEEF, 2'd0, "R9 new ctl");
    send(1, 32'h0008_0001, 2'd0, "R9 other ch unaffected");
    write_ctl(0, 8'hFF);
    send(0, 32'h1234_5678, 2'd1, "R9 ignored bits");
    write_ctl(0, 8'h8E);
    @(negedge clk); in_valid[0] = 1'b1;
    @(negedge clk); in_valid = '0;
    chk(ov0[0] == 1'b0, "R9 ignored bits no enable", 32'(ov0[0]), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule